// File: doc/BRIEF.md
# I2C Serial Clock Period Timer

This block produces the serial clock level for an I2C master from the system clock, using a 7-bit timer period value. A prescale counter divides the system clock by 2×(1+period). Each wrap of that counter is one time unit, and ten units form one SCL period. SCL is pulled low for the first six units and released for the last four. Single-cycle strobes mark each falling and rising edge that the timer creates. A bit-level state machine uses these strobes to shift data and to sample it.

The clock runs only while the block is enabled and a run request is present. With the run request removed, SCL is held at a requested level, low or released, and no strobes are issued. While the released clock is sensed low on the bus, the high phase pauses, so a slave can stretch the clock. A new period value is taken up only when a new SCL period begins. The sense input must already be synchronous to the system clock.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, scl_drv is 1 (released) and tick_rise and tick_fall are 0.
- R2: While running with period value p (0..127), the low phase lasts 12×(1+p) system clocks and the high phase 8×(1+p), so the SCL period is 20×(1+p) clocks. Examples: p=9 gives 200 clocks (100 kbps at 20 MHz), and p=0x27 gives 800 clocks (100 kbps at 80 MHz).
- R3: tick_fall is 1 for exactly one cycle, in the first cycle that scl_drv is 0 after the timer pulls it low. tick_rise is 1 for exactly one cycle, in the first cycle that scl_drv is 1 after the timer releases it. The two are never 1 together.
- R4: In the high phase, every cycle in which scl_in is 0 adds one cycle to the high phase. scl_in has no effect during the low phase.
- R5: A change to period takes effect from the next falling edge created by the timer. The SCL period in progress completes with the old value.
- R6: With en=0, from the next cycle scl_drv is 1 and no tick is issued. When en returns to 1 with run=1, a fresh full low phase starts.
- R7: With en=1 and run=0, from the next cycle scl_drv equals hold_hi (0 = held low, 1 = released) and no tick is issued.
- R8: When the clock starts (en=1 and run=1 after being stopped), SCL is pulled low in the next cycle and a full low phase of 12×(1+p) clocks follows. tick_fall is issued at that point only if scl_drv was 1 just before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; 0 releases SCL and stops the timer |
| run | input | 1 | 1 = generate the clock, 0 = hold SCL at hold_hi |
| hold_hi | input | 1 | Level held while run is 0: 1 released, 0 low |
| period | input | 7 | Timer period value p; SCL period is 20×(1+p) clocks |
| scl_in | input | 1 | Sensed SCL bus level, synchronous to clk |
| scl_drv | output | 1 | SCL drive: 0 pull low, 1 release |
| tick_rise | output | 1 | One-cycle strobe at a timer-made rising edge |
| tick_fall | output | 1 | One-cycle strobe at a timer-made falling edge |

## Verification
A table of period values runs through the timer back to back: 0, 127, the standard and fast mode settings, and values in between. The low and high lengths measured for each value separate a correct 6:4 split with a 2×(1+p) prescale from an off-by-one divider or from a swapped phase split. Each period measured right after a change must still carry the old value, which exposes a period value that is taken up at once. Directed cases stretch the high phase by a known number of cycles and hold SCL low and high. They also start from each hold level and drop the enable mid-phase. These cases separate pausing from restarting, and they check that a tick is suppressed when SCL is already low.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  // Time units that make up one SCL period, split low then high.
  localparam int LOW_UNITS    = 6;
  localparam int HIGH_UNITS   = 4;
  localparam int PERIOD_UNITS = LOW_UNITS + HIGH_UNITS;
  localparam int UNIT_W       = $clog2(PERIOD_UNITS);

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_RUN  = 2'd2
  } scl_mode_e;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic          cnt_en,
  input  logic [PW-1:0] period,
  output logic          wrap
);
  localparam int CW = PW + 1;

  logic [PW-1:0] per_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  // Division by 2*(1+p): the count runs 0 .. 2p+1.
  assign lim  = {per_q, 1'b1};
  assign wrap = cnt_en && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
    end else if (load) begin
      per_q <= period;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import i2c_scl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  scl_mode_e mode,
  input  logic      hold_hi,
  input  logic      unit,
  output logic      active,
  output logic      starting,
  output logic      last_unit,
  output logic      in_high,
  output logic      scl_drv,
  output logic      tick_rise,
  output logic      tick_fall
);
  logic [UNIT_W-1:0] ucnt;

  assign starting  = (mode == MODE_RUN) && !active;
  assign last_unit = active && (ucnt == UNIT_W'(PERIOD_UNITS - 1));
  assign in_high   = active && (ucnt >= UNIT_W'(LOW_UNITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      ucnt      <= '0;
      scl_drv   <= 1'b1;
      tick_rise <= 1'b0;
      tick_fall <= 1'b0;
    end else begin
      tick_rise <= 1'b0;
      tick_fall <= 1'b0;
      case (mode)
        MODE_OFF: begin
          active  <= 1'b0;
          ucnt    <= '0;
          scl_drv <= 1'b1;
        end
        MODE_HOLD: begin
          active  <= 1'b0;
          ucnt    <= '0;
          scl_drv <= hold_hi;
        end
        default: begin
          if (!active) begin
            active    <= 1'b1;
            ucnt      <= '0;
            scl_drv   <= 1'b0;
            tick_fall <= scl_drv;
          end else if (unit) begin
            if (last_unit) begin
              ucnt      <= '0;
              scl_drv   <= 1'b0;
              tick_fall <= 1'b1;
            end else begin
              ucnt <= ucnt + 1'b1;
              if (ucnt == UNIT_W'(LOW_UNITS - 1)) begin
                scl_drv   <= 1'b1;
                tick_rise <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_pkg::*;
#(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          run,
  input  logic          hold_hi,
  input  logic [PW-1:0] period,
  input  logic          scl_in,
  output logic          scl_drv,
  output logic          tick_rise,
  output logic          tick_fall
);
  scl_mode_e mode;
  logic      active, starting, last_unit, in_high;
  logic      pause, cnt_en, wrap, load;

  always_comb begin
    if (!en)       mode = MODE_OFF;
    else if (!run) mode = MODE_HOLD;
    else           mode = MODE_RUN;
  end

  // A released clock sensed low holds the high-phase count (stretching).
  assign pause  = in_high && !scl_in;
  assign cnt_en = active && !pause;
  assign load   = starting || (wrap && last_unit);

  scl_prescaler #(.PW(PW)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr    (!active),
    .load   (load),
    .cnt_en (cnt_en),
    .period (period),
    .wrap   (wrap)
  );

  scl_phase_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .hold_hi   (hold_hi),
    .unit      (wrap),
    .active    (active),
    .starting  (starting),
    .last_unit (last_unit),
    .in_high   (in_high),
    .scl_drv   (scl_drv),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall)
  );
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic run,
  input logic hold_hi,
  input logic scl_in,
  input logic in_high,
  input logic scl_drv,
  input logic tick_rise,
  input logic tick_fall
);
  // R3
  tick_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tick_rise && tick_fall));

  // R3
  fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
    tick_fall |-> (!scl_drv && $past(scl_drv)));

  // R3
  rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
    tick_rise |-> (scl_drv && !$past(scl_drv)));

  // R6
  off_release_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_drv && !tick_rise && !tick_fall));

  // R7
  hold_level_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !run) |=> (scl_drv == $past(hold_hi) && !tick_rise && !tick_fall));

  // R4
  stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && run && in_high && !scl_in) |=> (scl_drv && !tick_fall));
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .run       (run),
  .hold_hi   (hold_hi),
  .scl_in    (scl_in),
  .in_high   (in_high),
  .scl_drv   (scl_drv),
  .tick_rise (tick_rise),
  .tick_fall (tick_fall)
);

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;
  logic       clk = 1'b0;
  logic       rst, en, run, hold_hi, stretch;
  logic [6:0] period;
  logic       scl_in, scl_drv, tick_rise, tick_fall;
  int         tests = 0;
  int         fails = 0;
  bit         done  = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_in = scl_drv && !stretch;

  i2c_scl_timer u_dut (
    .clk(clk), .rst(rst), .en(en), .run(run), .hold_hi(hold_hi),
    .period(period), .scl_in(scl_in), .scl_drv(scl_drv),
    .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  // Vectors: period value, expected low cycles, expected high cycles.
  localparam int NV = 8;
  localparam int VP[NV] = '{9, 2, 6, 1, 24, 39, 0, 127};
  localparam int VL[NV] = '{120, 36, 84, 24, 300, 480, 12, 1536};
  localparam int VH[NV] = '{80, 24, 56, 16, 200, 320, 8, 1024};

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Starts at a negedge showing tick_fall; returns at the next one.
  task automatic measure(output int lo, output int hi, output int bad);
    lo = 0; hi = 0; bad = 0;
    do begin
      @(negedge clk); lo++;
      if (tick_fall || (!tick_rise && scl_drv)) bad++;
    end while (!tick_rise);
    do begin
      @(negedge clk); hi++;
      if (tick_rise || (!tick_fall && !scl_drv)) bad++;
    end while (!tick_fall);
  endtask

  task automatic quiet(input int n, input logic lvl, output int bad);
    bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (tick_rise || tick_fall || scl_drv != lvl) bad++;
    end
  endtask

  task automatic count_low(output int lo);
    lo = 0;
    do begin @(negedge clk); lo++; end while (!tick_rise);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int lo, hi, bad, n;
    rst = 1; en = 0; run = 0; hold_hi = 1; stretch = 0; period = 7'd9;
    repeat (4) @(negedge clk);
    chk("R1 scl_drv", scl_drv, 1);
    chk("R1 ticks", tick_rise + tick_fall, 0);
    rst = 0;
    en = 1; run = 1;
    @(negedge clk);
    chk("R8 tick_fall from released", tick_fall, 1);
    chk("R8 scl low at start", scl_drv, 0);

    // Table walk: each change first shows the old period, then the new one.
    for (int i = 0; i < NV; i++) begin
      period = 7'(VP[i]);
      measure(lo, hi, bad);
      if (i > 0) begin
        chk("R5 old low kept", lo, VL[i-1]);
        chk("R5 old high kept", hi, VH[i-1]);
      end
      measure(lo, hi, bad);
      chk("R2 low length", lo, VL[i]);
      chk("R2 high length", hi, VH[i]);
      chk("R3 single-cycle ticks", bad, 0);
    end

    // Switch to p=2 (low 36, high 24) for the directed tests.
    period = 7'd2;
    measure(lo, hi, bad);
    measure(lo, hi, bad);
    chk("R2 p2 period", lo + hi, 60);

    // R4: stretch asserted across the low phase, held 15 cycles into high.
    stretch = 1;
    count_low(n);
    chk("R4 low unaffected", n, 36);
    bad = 0;
    n = 0;
    repeat (15) begin
      @(negedge clk); n++;
      if (!scl_drv || tick_fall) bad++;
    end
    stretch = 0;
    do begin @(negedge clk); n++; end while (!tick_fall);
    chk("R4 high stretched", n, 24 + 15);
    chk("R4 released during stretch", bad, 0);

    // R7: hold low, then hold released.
    run = 0; hold_hi = 0;
    @(negedge clk);
    chk("R7 held low", scl_drv, 0);
    quiet(50, 1'b0, bad);
    chk("R7 low hold quiet", bad, 0);
    hold_hi = 1;
    @(negedge clk);
    chk("R7 held high", scl_drv, 1);
    quiet(50, 1'b1, bad);
    chk("R7 high hold quiet", bad, 0);

    // R8: start from the released hold.
    run = 1;
    @(negedge clk);
    chk("R8 tick_fall on start", tick_fall, 1);
    count_low(n);
    chk("R8 full low after start", n, 36);

    // R8: start from the low hold issues no fall tick.
    run = 0; hold_hi = 0;
    repeat (3) @(negedge clk);
    run = 1;
    @(negedge clk);
    chk("R8 low at start", scl_drv, 0);
    chk("R8 no tick when already low", tick_fall, 0);
    count_low(n);
    chk("R8 full low from low hold", n, 36);

    // R6: disable mid-phase, then re-enable.
    repeat (5) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk("R6 released when off", scl_drv, 1);
    quiet(50, 1'b1, bad);
    chk("R6 no ticks when off", bad, 0);
    en = 1;
    @(negedge clk);
    chk("R6 fresh start tick", tick_fall, 1);
    count_low(n);
    chk("R6 fresh full low", n, 36);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule